// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block steers one direction of a DMA channel through a linked list of descriptors held in memory. Software hands it the word address of the first descriptor with a single head write. The walker then reads that descriptor word by word over a request/response memory port, collects its frame control word and status word, and offers each address/length buffer entry as a beat on a valid/ready output stream to a data mover. When a descriptor's buffer list is finished, it fetches the link word and either moves on to the linked descriptor or stops.

The link word is read only after the last buffer of a descriptor has been accepted downstream. Software can therefore extend a running chain by patching the tail descriptor's link word, provided it does so before that descriptor's last buffer is taken. If the walker has already stopped, a new head write starts it again. Busy state and a sticky error flag are plain status pins. Frame completion and chain end are one-cycle pulses.

Back-pressure rules: on the memory request port the walker holds `rd_valid` and `rd_addr` steady until `rd_ready` is high at a clock edge. It keeps at most one read outstanding and takes the response on the first cycle with `rsp_valid` high. On the buffer port every beat field stays stable while `buf_valid` is high and `buf_ready` is low. A beat moves on a clock edge where both are high.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, status is 0 (bit 0 busy clear, bit 1 error clear), and `rd_valid`, `buf_valid`, `frame_done` and `chain_end` are low.
- R2: A head write with a nonzero address while idle starts a walk at that address, and status bit 0 reads 1 from the next cycle until the chain ends. A head write of address 0 while idle is ignored: busy stays 0 and no read is issued.
- R3: Descriptor layout, in word addresses relative to the descriptor base: word 0 link, word 1 frame control, word 2 status, then buffer pair k at words 3+2k (buffer address) and 4+2k (length word). Each beat carries the descriptor's control word on `buf_ctrl` and its status word on `buf_stat`.
- R4: Each buffer pair produces exactly one beat, in list order, with `buf_addr` equal to the address word and `buf_len` equal to bits 15:0 of the length word (bits 30:16 are ignored). A stalled beat holds all of its fields.
- R5: A length word with bit 31 set ends the descriptor's buffer list, and that beat has `buf_last` = 1. Earlier beats have `buf_last` = 0.
- R6: A descriptor carries at most 8 pairs. If the eighth pair's length word lacks bit 31, that beat is still marked last and no further pair is read.
- R7: `frame_done` is high for exactly one cycle, in the cycle after the edge that accepts a beat with `buf_last` = 1.
- R8: The link word is fetched after the last beat is accepted. A nonzero link continues at that address. A zero link gives a one-cycle `chain_end` pulse, and busy reads 0 from the cycle after.
- R9: A link patched into the tail before its last beat is accepted extends the running chain. After the walker has stopped, a new head write restarts it.
- R10: A head write while busy is ignored and sets status bit 1. Only reset clears that bit.
- R11: The read port keeps at most one request outstanding and holds `rd_valid` and `rd_addr` stable until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_wr | input | 1 | Head register write strobe |
| head_addr | input | AW | Word address of the first descriptor |
| status | output | 2 | Bit 0 busy, bit 1 sticky error |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | AW | Word address to read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| buf_valid | output | 1 | Buffer beat valid |
| buf_ready | input | 1 | Buffer beat accepted |
| buf_addr | output | DW | Buffer address |
| buf_len | output | LENW | Buffer length in bytes |
| buf_last | output | 1 | Last buffer of the descriptor |
| buf_ctrl | output | DW | Frame control word of the descriptor |
| buf_stat | output | DW | Status word of the descriptor |
| frame_done | output | 1 | One-cycle pulse per finished descriptor |
| chain_end | output | 1 | One-cycle pulse when a zero link is read |

## Verification
Two events can land in the same cycle: a software head write, and the arrival of the zero link that ends the chain. In that cycle the walker still counts as busy, so the write must be refused and flagged instead of being taken as a restart. The bench's memory model raises a head write in the very cycle it returns the zero link word. The run passes only if the error bit sets, `chain_end` pulses once, and no further read or beat follows. A second overlap also gets checked: the bench stalls the buffer port and patches the tail link during the stall. That edit has to take effect even though the descriptor fetch began before it.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT, W_EMIT} walk_st_t;
  typedef enum logic [1:0] {R_IDLE, R_REQ, R_WAIT} rd_st_t;
endpackage

// File: rtl/dcw_reader.sv
module dcw_reader import dcw_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic [DW-1:0] done_data
);
  rd_st_t        st;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        R_IDLE: if (go) begin
          addr_q <= go_addr;
          st     <= R_REQ;
        end
        R_REQ:  if (rd_ready) st <= R_WAIT;
        R_WAIT: if (rsp_valid) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  assign rd_valid  = (st == R_REQ);
  assign rd_addr   = addr_q;
  assign done      = (st == R_WAIT) && rsp_valid;
  assign done_data = rsp_data;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> st == R_IDLE);
endmodule

// File: rtl/dcw_seq.sv
module dcw_seq import dcw_pkg::*; #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 16,
  parameter int MAXP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  output logic            go,
  output logic [AW-1:0]   go_addr,
  input  logic            done,
  input  logic [DW-1:0]   done_data,
  output logic            buf_valid,
  input  logic            buf_ready,
  output logic [DW-1:0]   buf_addr,
  output logic [LENW-1:0] buf_len,
  output logic            buf_last,
  output logic [DW-1:0]   buf_ctrl,
  output logic [DW-1:0]   buf_stat,
  output logic            busy,
  output logic            frame_fire,
  output logic            chain_fire
);
  localparam int WIDXW = $clog2(3 + 2 * MAXP);
  localparam int PW    = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [PW-1:0] LAST_PAIR = PW'(MAXP - 1);

  walk_st_t       st;
  logic [AW-1:0]  base;
  logic [WIDXW-1:0] widx;
  logic [PW-1:0]  pair;
  logic [DW-1:0]  ctrl_q, stat_q, addr_q, len_q;
  logic           beat_last, beat_fire;

  assign beat_last  = len_q[DW-1] || (pair == LAST_PAIR);
  assign beat_fire  = (st == W_EMIT) && buf_ready;
  assign frame_fire = beat_fire && beat_last;
  assign chain_fire = (st == W_WAIT) && done && (widx == '0) && (done_data == '0);
  assign go         = (st == W_ISSUE);
  assign go_addr    = base + AW'(widx);
  assign busy       = (st != W_IDLE);

  assign buf_valid = (st == W_EMIT);
  assign buf_addr  = addr_q;
  assign buf_len   = len_q[LENW-1:0];
  assign buf_last  = beat_last;
  assign buf_ctrl  = ctrl_q;
  assign buf_stat  = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      base   <= '0;
      widx   <= '0;
      pair   <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          base <= start_addr;
          widx <= WIDXW'(1);
          st   <= W_ISSUE;
        end
        W_ISSUE: st <= W_WAIT;
        W_WAIT: if (done) begin
          if (widx == '0) begin
            if (done_data == '0) begin
              st <= W_IDLE;
            end else begin
              base <= done_data[AW-1:0];
              widx <= WIDXW'(1);
              st   <= W_ISSUE;
            end
          end else if (widx == WIDXW'(1)) begin
            ctrl_q <= done_data;
            widx   <= WIDXW'(2);
            st     <= W_ISSUE;
          end else if (widx == WIDXW'(2)) begin
            stat_q <= done_data;
            widx   <= WIDXW'(3);
            pair   <= '0;
            st     <= W_ISSUE;
          end else if (widx[0]) begin
            addr_q <= done_data;
            widx   <= widx + WIDXW'(1);
            st     <= W_ISSUE;
          end else begin
            len_q <= done_data;
            st    <= W_EMIT;
          end
        end
        W_EMIT: if (buf_ready) begin
          if (beat_last) begin
            widx <= '0;
          end else begin
            widx <= widx + WIDXW'(1);
            pair <= pair + PW'(1);
          end
          st <= W_ISSUE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len)
      && $stable(buf_last) && $stable(buf_ctrl));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/dcw_events.sv
module dcw_events #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_wr,
  input  logic [AW-1:0] head_addr,
  input  logic          busy,
  input  logic          frame_fire,
  input  logic          chain_fire,
  output logic          start,
  output logic          err,
  output logic          frame_done,
  output logic          chain_end
);
  assign start = head_wr && !busy && (head_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err        <= 1'b0;
      frame_done <= 1'b0;
      chain_end  <= 1'b0;
    end else begin
      if (head_wr && busy) err <= 1'b1;
      frame_done <= frame_fire;
      chain_end  <= chain_fire;
    end
  end

  // R10
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr && busy |=> err);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_fire |=> !busy);
  // R7
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 16,
  parameter int MAXP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_wr,
  input  logic [AW-1:0]   head_addr,
  output logic [1:0]      status,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            buf_valid,
  input  logic            buf_ready,
  output logic [DW-1:0]   buf_addr,
  output logic [LENW-1:0] buf_len,
  output logic            buf_last,
  output logic [DW-1:0]   buf_ctrl,
  output logic [DW-1:0]   buf_stat,
  output logic            frame_done,
  output logic            chain_end
);
  logic          start, go, done, busy, err, frame_fire, chain_fire;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] done_data;

  dcw_events #(.AW(AW)) u_evt (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_addr(head_addr),
    .busy(busy), .frame_fire(frame_fire), .chain_fire(chain_fire),
    .start(start), .err(err), .frame_done(frame_done), .chain_end(chain_end));

  dcw_seq #(.AW(AW), .DW(DW), .LENW(LENW), .MAXP(MAXP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(head_addr),
    .go(go), .go_addr(go_addr), .done(done), .done_data(done_data),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
    .buf_len(buf_len), .buf_last(buf_last), .buf_ctrl(buf_ctrl),
    .buf_stat(buf_stat), .busy(busy), .frame_fire(frame_fire),
    .chain_fire(chain_fire));

  dcw_reader #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .done_data(done_data));

  assign status = {err, busy};
endmodule

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;
  typedef struct packed {
    logic [31:0] a;
    logic [15:0] l;
    logic        last;
    logic [31:0] c;
    logic [31:0] s;
  } beat_t;

  logic        clk = 0, rst_n = 0;
  logic        hw_t = 0, inj_wr = 0, head_wr;
  logic [15:0] ha_t = 0, inj_addr = 0, head_addr;
  logic [1:0]  status;
  logic        rd_valid, rd_ready = 0, rsp_valid = 0;
  logic [15:0] rd_addr;
  logic [31:0] rsp_data = 0;
  logic        buf_valid, buf_ready = 0, buf_last, frame_done, chain_end;
  logic [31:0] buf_addr, buf_ctrl, buf_stat;
  logic [15:0] buf_len;

  logic [31:0] mem [0:63];
  beat_t exp_q[$];
  int total = 0, bad = 0, n_frame = 0, n_end = 0, ready_mode = 0, lat = 0;
  int cyc = 0;
  bit inj_on = 0, frame_chk = 0, stall_seen = 0;
  logic [15:0] inj_match = 0;
  logic [31:0] stall_addr = 0;

  assign head_wr   = hw_t | inj_wr;
  assign head_addr = inj_wr ? inj_addr : ha_t;

  always #10 clk = ~clk;

  desc_chain_walker #(.AW(16), .DW(32), .LENW(16), .MAXP(8)) u0 (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_addr(head_addr),
    .status(status), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .buf_valid(buf_valid),
    .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_last(buf_last), .buf_ctrl(buf_ctrl), .buf_stat(buf_stat),
    .frame_done(frame_done), .chain_end(chain_end));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model with one-cycle ready pulses and a variable latency
  initial begin
    logic [15:0] a;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        a = rd_addr;
        repeat (lat) @(negedge clk);
        chk(rd_valid && rd_addr == a, "R11 request held", {rd_valid, rd_addr}, {1'b1, a});
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0;
        repeat (lat) @(negedge clk);
        if (rd_valid) chk(0, "R11 second request outstanding", 1, 0);
        rsp_valid = 1;
        rsp_data  = mem[a[5:0]];
        if (inj_on && a == inj_match && mem[a[5:0]] == 0) begin
          inj_wr = 1; inj_addr = 16'd2;
        end
        @(negedge clk);
        rsp_valid = 0;
        inj_wr    = 0;
      end
    end
  end

  // sink and scoreboard monitor
  initial begin
    beat_t got, e;
    forever begin
      @(negedge clk);
      cyc++;
      if (frame_done) n_frame++;
      if (chain_end) n_end++;
      if (frame_chk) begin
        chk(frame_done == 1, "R7 frame_done after last beat", frame_done, 1);
        frame_chk = 0;
      end
      if (stall_seen) begin
        chk(buf_valid && buf_addr == stall_addr, "R4 stalled beat held", buf_addr, stall_addr);
        stall_seen = 0;
      end
      buf_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
      if (buf_valid && !buf_ready) begin
        stall_seen = 1; stall_addr = buf_addr;
      end
      if (buf_valid && buf_ready) begin
        got = '{buf_addr, buf_len, buf_last, buf_ctrl, buf_stat};
        if (exp_q.size() == 0) chk(0, "R4 unexpected beat", got, 0);
        else begin
          e = exp_q.pop_front();
          chk(got == e, "R3 R4 R5 R6 beat contents", got, e);
        end
        if (buf_last) frame_chk = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'hBAD0_0000 | i;
  endtask

  task automatic build(input int base, input int nxt, input int n, input bit flag, input bit push);
    beat_t e;
    mem[base]     = nxt;
    mem[base + 1] = 32'hC000_0000 | base;
    mem[base + 2] = 32'h5A00_0000 | (base << 4);
    for (int i = 0; i < n; i++) begin
      mem[base + 3 + 2*i] = 32'h1000_0000 + base * 256 + i;
      mem[base + 4 + 2*i] = 32'h0055_0000 | (base + i * 7 + 1) |
                            ((flag && i == n - 1) ? 32'h8000_0000 : 0);
      e.a = mem[base + 3 + 2*i];
      e.l = 16'(base + i * 7 + 1);
      e.last = (i == n - 1);
      e.c = mem[base + 1];
      e.s = mem[base + 2];
      if (push) exp_q.push_back(e);
    end
  endtask

  task automatic head_write(input logic [15:0] a);
    @(negedge clk);
    hw_t = 1; ha_t = a;
    @(negedge clk);
    hw_t = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && status[0]; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int f0, e0;
    clear_mem();
    do_reset();
    // R1
    chk(status == 2'b00, "R1 status after reset", status, 0);
    chk(!rd_valid && !buf_valid && !frame_done && !chain_end, "R1 outputs idle",
        {rd_valid, buf_valid, frame_done, chain_end}, 0);

    // single descriptor, two buffers
    build(2, 0, 2, 1, 1);
    f0 = n_frame; e0 = n_end;
    head_write(2);
    chk(status[0] == 1, "R2 busy after head write", status, 1);
    wait_idle();
    chk(exp_q.size() == 0, "R4 all beats seen single", exp_q.size(), 0);
    chk(n_frame - f0 == 1, "R7 one frame", n_frame - f0, 1);
    chk(n_end - e0 == 1 && status == 0, "R8 chain end idle", {n_end - e0, status}, {32'd1, 2'b0});

    // three-descriptor chain, slow sink and slow memory
    clear_mem(); ready_mode = 1; lat = 2;
    build(2, 24, 1, 1, 1); build(24, 44, 3, 1, 1); build(44, 0, 8, 1, 1);
    f0 = n_frame; e0 = n_end;
    head_write(2);
    wait_idle();
    chk(exp_q.size() == 0, "R8 chain followed", exp_q.size(), 0);
    chk(n_frame - f0 == 3, "R7 three frames", n_frame - f0, 3);
    chk(n_end - e0 == 1, "R8 single chain end", n_end - e0, 1);

    // eight pairs, no flag, poisoned ninth pair
    clear_mem(); ready_mode = 0; lat = 0;
    build(2, 0, 8, 0, 1);
    mem[21] = 32'hDEAD_0001; mem[22] = 32'h8000_0010;
    f0 = n_frame;
    head_write(2);
    wait_idle();
    chk(exp_q.size() == 0, "R6 capped at eight", exp_q.size(), 0);
    chk(n_frame - f0 == 1, "R6 frame after forced last", n_frame - f0, 1);

    // append by patching the tail link during a stall
    clear_mem(); ready_mode = 2;
    build(2, 0, 2, 1, 1);
    f0 = n_frame; e0 = n_end;
    head_write(2);
    repeat (20) @(negedge clk);
    build(24, 0, 1, 1, 1);
    mem[2] = 24;
    ready_mode = 0;
    wait_idle();
    chk(exp_q.size() == 0, "R9 patched link followed", exp_q.size(), 0);
    chk(n_frame - f0 == 2 && n_end - e0 == 1, "R9 frames after append",
        {n_frame - f0, n_end - e0}, {32'd2, 32'd1});

    // restart after the walker stopped
    build(44, 0, 1, 1, 1);
    head_write(44);
    wait_idle();
    chk(exp_q.size() == 0, "R9 restart walk", exp_q.size(), 0);

    // head write of zero while idle
    head_write(0);
    chk(status == 2'b00 && !rd_valid, "R2 zero head ignored", {status, rd_valid}, 0);

    // head write in the same cycle as the zero link response
    clear_mem();
    build(2, 0, 1, 1, 1);
    inj_on = 1; inj_match = 2;
    f0 = n_frame; e0 = n_end;
    head_write(2);
    wait_idle();
    inj_on = 0;
    chk(status == 2'b10, "R10 coincident write refused", status, 2'b10);
    chk(n_end - e0 == 1 && exp_q.size() == 0, "R8 coincident single end",
        {n_end - e0, exp_q.size()}, {32'd1, 32'd0});
    chk(!rd_valid && !buf_valid, "R10 no restart", {rd_valid, buf_valid}, 0);

    // head write while busy
    do_reset();
    chk(status == 2'b00, "R1 error cleared by reset", status, 0);
    clear_mem(); ready_mode = 2;
    build(2, 0, 2, 1, 1);
    build(24, 0, 1, 1, 0);
    head_write(2);
    repeat (10) @(negedge clk);
    head_write(24);
    chk(status == 2'b11, "R10 busy write flagged", status, 2'b11);
    ready_mode = 0;
    wait_idle();
    chk(exp_q.size() == 0, "R10 ignored head had no effect", exp_q.size(), 0);
    chk(status == 2'b10, "R10 error sticky", status, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule